// File: doc/BRIEF.md
# Guarded Instruction Issue Gate

This block sits at the issue point of an in-order pipeline and rules on every instruction that names a guard register. A guard that holds a non-zero value lets the instruction complete and write its result. A guard that holds zero turns it into a no-op, with no register write and no memory access. The guard's readiness and value come from a scoreboard outside the block, one ready bit and one non-zero bit per guard register. Instructions that carry no guard pass straight through.

Two policies are available and a mode input selects between them. In the waiting policy, a guarded instruction whose guard is still being produced is held at issue. In the early policy, that instruction issues at once and is given a slot tag in a small in-order table. Later, when its guard becomes ready, the table head is resolved as kept or squashed. Squashed instructions are wasted work and are counted. The table is drained strictly in allocation order, so the ruling for a younger instruction never passes the ruling for an older one.

Top module: `pred_issue_gate`

## Requirements
- R1: After reset the tag table is empty, `res_valid` is 0 and `squash_cnt` is 0.
- R2: An instruction with `in_pred`=0 is always accepted (`in_ready`=1), with `issue_null`=0 and `issue_spec`=0, whatever the guard state, the mode or the table fill.
- R3: In either mode, with the table empty, a guarded instruction whose guard is ready and non-zero is accepted in the same cycle, with `issue_null`=0 and `issue_spec`=0.
- R4: In either mode, with the table empty, a guarded instruction whose guard is ready and zero is accepted in the same cycle, with `issue_null`=1 and `issue_spec`=0.
- R5: With `late_mode`=0, a guarded instruction whose guard ready bit is 0 is not accepted: `in_ready`=0, and `stall`=1 while `in_valid`=1.
- R6: With `late_mode`=1 and the table not full, a guarded instruction whose guard is not ready, or that arrives while the table holds entries, is accepted with `issue_spec`=1. `spec_tag` then gives its slot. Slots are handed out as 0,1,…,DEPTH-1 and then wrap to 0.
- R7: With `late_mode`=1, a guarded instruction that meets a ready guard and an empty table is settled at issue, exactly as in R3 and R4, and takes no slot.
- R8: While the table holds DEPTH (default 4) entries, every guarded instruction is refused in either mode. Instructions with no guard still pass.
- R9: The oldest table entry is resolved in the first cycle its guard ready bit reads 1, combinationally: `res_valid`=1, `res_tag` gives its slot, and `res_squash`=1 exactly when the guard is zero. At most one entry is resolved per cycle. A younger entry never resolves before an older one, even if its guard is ready first.
- R10: `squash_cnt` rises by one, wrapping at its width, in the cycle after each resolution that has `res_squash`=1. It is unchanged otherwise.
- R11: With `late_mode`=0, a guarded instruction is refused while the table still holds entries, even if its own guard is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| late_mode | input | 1 | 0: wait for guard at issue; 1: issue early, squash later |
| in_valid | input | 1 | Instruction present at issue |
| in_ready | output | 1 | Gate accepts the instruction this cycle |
| in_pred | input | 1 | Instruction carries a guard operand |
| in_guard | input | IDX_W ($clog2(NREG)) | Guard register index |
| sb_ready | input | NREG | Per-register guard ready bits from the scoreboard |
| sb_nz | input | NREG | Per-register guard non-zero bits |
| issue_fire | output | 1 | Instruction issued this cycle |
| issue_null | output | 1 | Issued instruction is a no-op |
| issue_spec | output | 1 | Issued instruction awaits a later ruling |
| spec_tag | output | TAG_W ($clog2(DEPTH)) | Slot given to an early-issued instruction |
| stall | output | 1 | Instruction present but held |
| res_valid | output | 1 | Oldest early-issued instruction ruled on this cycle |
| res_squash | output | 1 | The ruling is a squash |
| res_tag | output | TAG_W | Slot being ruled on |
| squash_cnt | output | CNT_W | Count of squashed instructions |

## Verification
The hardest state to reach is a full table whose oldest entry waits on a guard that is still pending, while a younger entry's guard is already ready. This state is what shows in-order resolution, refusal on a full table and refusal in the waiting policy all at once. The stimulus reaches it by first withholding one guard's ready bit and issuing early against it, then queueing entries behind it whose guards are ready or also pending, until all slots are taken. Only after that are both policies probed, and then the pending guard is released.

// File: rtl/pred_gate_pkg.sv
package pred_gate_pkg;

  typedef enum logic [1:0] {
    ACT_WAIT = 2'd0,
    ACT_KEEP = 2'd1,
    ACT_NOOP = 2'd2
  } gate_act_e;

  // Ruling on a guard given its ready and non-zero bits.
  function automatic gate_act_e guard_action(input logic rdy, input logic nz);
    if (!rdy)     return ACT_WAIT;
    else if (nz)  return ACT_KEEP;
    else          return ACT_NOOP;
  endfunction

  // Whether an issuing guarded instruction must take a table slot.
  function automatic logic needs_slot(input logic late, input logic busy,
                                      input gate_act_e act);
    return late && (busy || (act == ACT_WAIT));
  endfunction

endpackage

// File: rtl/pred_guard_lookup.sv
module pred_guard_lookup #(
  parameter int NREG  = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [NREG-1:0]  sb_ready,
  input  logic [NREG-1:0]  sb_nz,
  output logic             rdy,
  output logic             nz
);
  always_comb begin
    rdy = sb_ready[idx];
    nz  = sb_nz[idx];
  end
endmodule

// File: rtl/pred_tag_fifo.sv
module pred_tag_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DATA_W-1:0]        push_data,
  input  logic                     pop,
  output logic [DATA_W-1:0]        head_data,
  output logic [$clog2(DEPTH)-1:0] head_tag,
  output logic [$clog2(DEPTH)-1:0] tail_tag,
  output logic                     empty,
  output logic                     full
);
  localparam int TAG_W = $clog2(DEPTH);
  localparam int PTR_W = TAG_W + 1;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  always_comb begin
    head_tag  = rd_ptr[TAG_W-1:0];
    tail_tag  = wr_ptr[TAG_W-1:0];
    empty     = (wr_ptr == rd_ptr);
    full      = (wr_ptr[TAG_W] != rd_ptr[TAG_W]) &&
                (wr_ptr[TAG_W-1:0] == rd_ptr[TAG_W-1:0]);
    head_data = slot_q[head_tag];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[tail_tag] <= push_data;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R9
  AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R8
endmodule

// File: rtl/pred_squash_counter.sv
module pred_squash_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end

  AST_SQUASH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (count == $past(count) + CNT_W'(1))); // R10
  AST_SQUASH_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count)); // R10
endmodule

// File: rtl/pred_issue_gate.sv
module pred_issue_gate
  import pred_gate_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 16,
  parameter int IDX_W = $clog2(NREG),
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             late_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_pred,
  input  logic [IDX_W-1:0] in_guard,
  input  logic [NREG-1:0]  sb_ready,
  input  logic [NREG-1:0]  sb_nz,
  output logic             issue_fire,
  output logic             issue_null,
  output logic             issue_spec,
  output logic [TAG_W-1:0] spec_tag,
  output logic             stall,
  output logic             res_valid,
  output logic             res_squash,
  output logic [TAG_W-1:0] res_tag,
  output logic [CNT_W-1:0] squash_cnt
);
  // Guard reads: one for the issuing instruction, one for the table head.
  logic             iss_rdy, iss_nz, hd_rdy, hd_nz;
  logic [IDX_W-1:0] hd_idx;
  logic             q_empty, q_full, q_busy;
  gate_act_e        iss_act, hd_act;
  logic             take_slot, pred_block;

  pred_guard_lookup #(.NREG(NREG), .IDX_W(IDX_W)) u_issue_lk (
    .idx(in_guard), .sb_ready(sb_ready), .sb_nz(sb_nz),
    .rdy(iss_rdy), .nz(iss_nz)
  );

  pred_guard_lookup #(.NREG(NREG), .IDX_W(IDX_W)) u_head_lk (
    .idx(hd_idx), .sb_ready(sb_ready), .sb_nz(sb_nz),
    .rdy(hd_rdy), .nz(hd_nz)
  );

  always_comb begin
    q_busy     = !q_empty;
    iss_act    = guard_action(iss_rdy, iss_nz);
    hd_act     = guard_action(hd_rdy, hd_nz);
    take_slot  = in_pred && needs_slot(late_mode, q_busy, iss_act);
    pred_block = in_pred && (late_mode ? (take_slot && q_full)
                                       : (q_busy || iss_act == ACT_WAIT));
    in_ready   = !pred_block;
    issue_fire = in_valid && in_ready;
    stall      = in_valid && pred_block;
    issue_spec = issue_fire && take_slot;
    issue_null = issue_fire && in_pred && !take_slot && (iss_act == ACT_NOOP);
    res_valid  = q_busy && (hd_act != ACT_WAIT);
    res_squash = res_valid && (hd_act == ACT_NOOP);
  end

  pred_tag_fifo #(.DEPTH(DEPTH), .DATA_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .push(issue_spec), .push_data(in_guard),
    .pop(res_valid),
    .head_data(hd_idx), .head_tag(res_tag), .tail_tag(spec_tag),
    .empty(q_empty), .full(q_full)
  );

  pred_squash_counter #(.CNT_W(CNT_W)) u_squash_ctr (
    .clk(clk), .rst_n(rst_n), .inc(res_squash), .count(squash_cnt)
  );

  AST_PLAIN_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_pred) |-> (in_ready && !issue_null && !issue_spec)); // R2
  AST_NULL_ONLY_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    issue_null |-> (iss_rdy && !iss_nz && q_empty)); // R4
  AST_WAIT_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pred && !late_mode && !iss_rdy) |-> (stall && !issue_fire)); // R5
  AST_SPEC_ONLY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_spec |-> (late_mode && !q_full)); // R6
  AST_RES_HEAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (hd_rdy && !q_empty)); // R9
  AST_WAIT_MODE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pred && !late_mode && !q_empty) |-> !in_ready); // R11
  AST_FIRE_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_fire && stall)); // R5
endmodule

// File: tb/pred_issue_gate_tb_top.sv
`timescale 1ns/1ps
module pred_issue_gate_tb_top;
  localparam int NREG  = 8;
  localparam int DEPTH = 4;
  localparam int CNT_W = 16;
  localparam int IDX_W = $clog2(NREG);
  localparam int TAG_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic late_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_pred = 1'b0;
  logic [IDX_W-1:0] in_guard = '0;
  logic [NREG-1:0] sb_ready = '1;
  logic [NREG-1:0] sb_nz = 8'b1110_1010;
  logic in_ready, issue_fire, issue_null, issue_spec, stall;
  logic res_valid, res_squash;
  logic [TAG_W-1:0] spec_tag, res_tag;
  logic [CNT_W-1:0] squash_cnt;

  int n_checks = 0;
  int n_fails = 0;
  int next_tag = 0;
  int exp_squashes = 0;
  bit last_was_squash = 1'b0;
  bit done = 1'b0;
  int exp_tag_q[$];
  bit exp_sq_q[$];

  always #2 clk = ~clk;

  pred_issue_gate #(.NREG(NREG), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .late_mode(late_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_pred(in_pred),
    .in_guard(in_guard), .sb_ready(sb_ready), .sb_nz(sb_nz),
    .issue_fire(issue_fire), .issue_null(issue_null), .issue_spec(issue_spec),
    .spec_tag(spec_tag), .stall(stall), .res_valid(res_valid),
    .res_squash(res_squash), .res_tag(res_tag), .squash_cnt(squash_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: presents one instruction, checks the issue ruling, records expected later rulings.
  task automatic send(input bit pred, input int idx, input bit exp_rdy,
                      input bit exp_null, input bit exp_spec, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_pred  = pred;
    in_guard = IDX_W'(idx);
    #1;
    chk(in_ready == exp_rdy, {req, " in_ready"}, int'(in_ready), int'(exp_rdy));
    chk(issue_fire == exp_rdy, {req, " issue_fire"}, int'(issue_fire), int'(exp_rdy));
    chk(stall == !exp_rdy, {req, " stall"}, int'(stall), int'(!exp_rdy));
    chk(issue_null == exp_null, {req, " issue_null"}, int'(issue_null), int'(exp_null));
    chk(issue_spec == exp_spec, {req, " issue_spec"}, int'(issue_spec), int'(exp_spec));
    if (exp_spec) begin
      chk(int'(spec_tag) == next_tag, {req, " spec_tag"}, int'(spec_tag), next_tag);
      exp_tag_q.push_back(next_tag);
      exp_sq_q.push_back(!sb_nz[idx]);
      next_tag = (next_tag + 1) % DEPTH;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_pred  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected rulings in order and compares (R9), tracks the squash count (R10).
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (last_was_squash)
        chk(int'(squash_cnt) == exp_squashes, "R10 squash_cnt step",
            int'(squash_cnt), exp_squashes);
      last_was_squash = 1'b0;
      if (res_valid) begin
        if (exp_tag_q.size() == 0) begin
          chk(1'b0, "R9 unexpected ruling", int'(res_tag), -1);
        end else begin
          int et;
          bit es;
          et = exp_tag_q.pop_front();
          es = exp_sq_q.pop_front();
          chk(int'(res_tag) == et, "R9 res_tag order", int'(res_tag), et);
          chk(res_squash == es, "R9 res_squash", int'(res_squash), int'(es));
        end
        if (res_squash) begin
          exp_squashes++;
          last_was_squash = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    chk(squash_cnt == '0, "R1 squash_cnt after reset", int'(squash_cnt), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // Waiting policy, all guards ready. nz: regs 1,3,5,6,7 non-zero.
    send(1, 1, 1, 0, 0, "R3 keep at issue");
    send(1, 2, 1, 1, 0, "R4 noop at issue");
    send(0, 2, 1, 0, 0, "R2 plain pass");

    @(negedge clk); sb_ready[4] = 1'b0;
    send(1, 4, 0, 0, 0, "R5 wait on pending guard");
    send(0, 4, 1, 0, 0, "R2 plain ignores pending guard");

    // Early policy: fill the table.
    @(negedge clk); late_mode = 1'b1; sb_ready[6] = 1'b0;
    send(1, 4, 1, 0, 1, "R6 early issue pending guard");
    send(1, 1, 1, 0, 1, "R6 early issue behind entry");
    send(1, 6, 1, 0, 1, "R6 early issue slot2");
    send(1, 6, 1, 0, 1, "R6 early issue slot3");
    send(1, 1, 0, 0, 0, "R8 full table refuses guarded");
    send(0, 1, 1, 0, 0, "R8 full table passes plain");
    @(negedge clk); #1;
    chk(res_valid == 1'b0, "R9 younger ready waits for head", int'(res_valid), 0);
    @(negedge clk); late_mode = 1'b0;
    send(1, 1, 0, 0, 0, "R11 waiting policy drains table first");

    // Release the head guard: squash slot0, keep slot1.
    @(negedge clk); sb_ready[4] = 1'b1;
    idle(3);
    chk(exp_tag_q.size() == 2, "R9 two rulings delivered", 4 - exp_tag_q.size(), 2);

    @(negedge clk); late_mode = 1'b1;
    send(1, 3, 1, 0, 1, "R6 wrap slot0 behind entries");
    @(negedge clk); sb_ready[6] = 1'b1;
    idle(5);
    chk(exp_tag_q.size() == 0, "R9 table drained", exp_tag_q.size(), 0);

    send(1, 2, 1, 1, 0, "R7 early policy settles at issue noop");
    send(1, 3, 1, 0, 0, "R7 early policy settles at issue keep");

    @(negedge clk); sb_ready[0] = 1'b0;
    send(1, 0, 1, 0, 1, "R6 early issue zero guard");
    idle(2);
    @(negedge clk); sb_ready[0] = 1'b1;
    idle(3);
    @(negedge clk); #1;
    chk(int'(squash_cnt) == 2, "R10 final squash count", int'(squash_cnt), 2);
    chk(exp_tag_q.size() == 0, "R9 all rulings seen", exp_tag_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule